// File: doc/BRIEF.md
# AES3 Transmit Subframe Mapper

This block sits in front of an AES3 / S/PDIF transmit framer. It accepts parallel audio samples, each carrying a left word, a right word and one channel-status bit per channel. It turns them into an ordered stream of subframes for the framer. Each subframe is tagged as slot A or slot B and carries one audio word and one channel-status bit. Biphase-mark coding, preambles, parity and clocking are left to the framer downstream.

In stereo mode, one input sample fills one frame: the left word goes to slot A and the right word to slot B. In mono mode, two input samples fill one frame. Both come from the same selected channel, and the first lands in slot A, the second in slot B. A separate control chooses where the channel-status bits come from. By default each slot takes its own channel's status. Otherwise both slots share the status of the selected channel.

The three mode controls are sampled only when a frame starts, so a frame is never mapped half one way and half another. Both edges use a ready/valid handshake.

Top module: `aes_tx_subframe_mapper`

## Requirements
- R1: After reset `sf_valid` is 0, and the first subframe delivered is a slot A subframe (`sf_slot_b` = 0).
- R2: With `cfg_mono` = 0, each accepted input sample gives one frame. Slot A carries `in_left` and slot B carries `in_right` of that sample.
- R3: With `cfg_mono` = 1, a frame consumes two input samples. Slot A carries the selected word of the first sample and slot B carries the selected word of the second.
- R4: The selected channel is left when `cfg_sel_right` = 0 and right when `cfg_sel_right` = 1.
- R5: With `cfg_cs_shared` = 0, `sf_cs` in slot A is `in_cs_left` and `sf_cs` in slot B is `in_cs_right`, each taken from the sample that feeds that slot.
- R6: With `cfg_cs_shared` = 1, `sf_cs` in both slots is the selected channel's status bit (`in_cs_left` when `cfg_sel_right` = 0, `in_cs_right` when 1) of the sample feeding that slot.
- R7: Delivered subframes strictly alternate A, B, A, B.
- R8: The three cfg inputs are sampled only when a slot A subframe is formed. A change while slot B is pending affects the next frame, not the current one.
- R9: While `sf_valid` = 1 and `sf_ready` = 0, `sf_valid`, `sf_data`, `sf_slot_b` and `sf_cs` stay unchanged.
- R10: In stereo mode `in_ready` stays 0 while the slot B subframe of the current frame is still pending, so no input is consumed for slot B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mono | input | 1 | 1 = mono transmit, 0 = stereo |
| cfg_sel_right | input | 1 | Channel select for mono data and shared status: 0 left, 1 right |
| cfg_cs_shared | input | 1 | 1 = both slots carry the selected channel's status bit |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| in_left | input | DATA_W | Left audio word |
| in_right | input | DATA_W | Right audio word |
| in_cs_left | input | 1 | Left channel-status bit |
| in_cs_right | input | 1 | Right channel-status bit |
| sf_valid | output | 1 | Subframe valid |
| sf_ready | input | 1 | Framer accepts subframe |
| sf_data | output | DATA_W | Subframe audio word |
| sf_slot_b | output | 1 | 0 = slot A, 1 = slot B |
| sf_cs | output | 1 | Subframe channel-status bit |

## Verification
The interesting collision is a cfg change arriving while the slot B subframe of a frame is still pending or being formed. The frame must finish under the old mapping, and the next frame must start under the new one. The bench provokes this by inverting all three cfg inputs right after the first input of a frame has been accepted. Meanwhile an irregular `sf_ready` pattern delays slot B by a varying number of cycles. The scoreboard expects the whole frame under its starting cfg, so any early pickup of the new cfg shows up as a wrong word, slot or status bit.

// File: rtl/aes_sfm_pkg.sv
package aes_sfm_pkg;

    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } sfm_slot_e;

    typedef struct packed {
        logic mono;
        logic sel_right;
        logic cs_shared;
    } sfm_cfg_t;

endpackage

// File: rtl/aes_sfm_slot_mux.sv
module aes_sfm_slot_mux
    import aes_sfm_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  sfm_cfg_t          cfg,
    input  sfm_slot_e         slot,
    input  logic [DATA_W-1:0] cur_left,
    input  logic [DATA_W-1:0] cur_right,
    input  logic              cur_cs_left,
    input  logic              cur_cs_right,
    input  logic [DATA_W-1:0] held_right,
    input  logic              held_cs_left,
    input  logic              held_cs_right,
    output logic [DATA_W-1:0] out_data,
    output logic              out_cs
);

    logic src_cs_l;
    logic src_cs_r;
    logic own_cs;
    logic shared_cs;

    always_comb begin
        // stereo slot B draws from the held sample, all other cases from the live one
        if (!cfg.mono && slot == SLOT_B) begin
            src_cs_l = held_cs_left;
            src_cs_r = held_cs_right;
            out_data = held_right;
        end else begin
            src_cs_l = cur_cs_left;
            src_cs_r = cur_cs_right;
            if (cfg.mono) begin
                out_data = cfg.sel_right ? cur_right : cur_left;
            end else begin
                out_data = cur_left;
            end
        end
        own_cs    = (slot == SLOT_A) ? src_cs_l : src_cs_r;
        shared_cs = cfg.sel_right ? src_cs_r : src_cs_l;
        out_cs    = cfg.cs_shared ? shared_cs : own_cs;
    end

endmodule

// File: rtl/aes_sfm_out_stage.sv
module aes_sfm_out_stage #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_slot_b,
    input  logic              load_cs,
    input  logic              sf_ready,
    output logic              can_load,
    output logic              sf_valid,
    output logic [DATA_W-1:0] sf_data,
    output logic              sf_slot_b,
    output logic              sf_cs
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              slot_b;
        logic              cs;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    always_comb begin
        can_load = !st_q.valid || sf_ready;
        st_d     = st_q;
        if (load && can_load) begin
            st_d.valid  = 1'b1;
            st_d.data   = load_data;
            st_d.slot_b = load_slot_b;
            st_d.cs     = load_cs;
        end else if (sf_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sf_valid  = st_q.valid;
    assign sf_data   = st_q.data;
    assign sf_slot_b = st_q.slot_b;
    assign sf_cs     = st_q.cs;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && !sf_ready) |=> (sf_valid && $stable(sf_data) && $stable(sf_slot_b) && $stable(sf_cs)));

    // R9
    load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> can_load);

endmodule

// File: rtl/aes_tx_subframe_mapper.sv
module aes_tx_subframe_mapper
    import aes_sfm_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mono,
    input  logic              cfg_sel_right,
    input  logic              cfg_cs_shared,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic              in_cs_left,
    input  logic              in_cs_right,
    output logic              sf_valid,
    input  logic              sf_ready,
    output logic [DATA_W-1:0] sf_data,
    output logic              sf_slot_b,
    output logic              sf_cs
);

    typedef struct packed {
        sfm_slot_e         slot;
        sfm_cfg_t          cfg;
        logic [DATA_W-1:0] hold_right;
        logic              hold_cs_left;
        logic              hold_cs_right;
    } seq_t;

    seq_t st_d;
    seq_t st_q;

    sfm_cfg_t          cfg_live;
    sfm_cfg_t          cfg_eff;
    logic              can_load;
    logic              take;
    logic              load;
    logic [DATA_W-1:0] mux_data;
    logic              mux_cs;

    always_comb begin
        cfg_live = '{mono: cfg_mono, sel_right: cfg_sel_right, cs_shared: cfg_cs_shared};
        // a frame's mapping is fixed when its slot A is formed
        cfg_eff  = (st_q.slot == SLOT_A) ? cfg_live : st_q.cfg;
        in_ready = can_load && (st_q.slot == SLOT_A || st_q.cfg.mono);
        take     = in_valid && in_ready;
        load     = take || (can_load && st_q.slot == SLOT_B && !st_q.cfg.mono);

        st_d = st_q;
        if (load) begin
            st_d.slot = (st_q.slot == SLOT_A) ? SLOT_B : SLOT_A;
            if (st_q.slot == SLOT_A) begin
                st_d.cfg           = cfg_live;
                st_d.hold_right    = in_right;
                st_d.hold_cs_left  = in_cs_left;
                st_d.hold_cs_right = in_cs_right;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{slot: SLOT_A, cfg: '0, hold_right: '0, hold_cs_left: 1'b0, hold_cs_right: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    aes_sfm_slot_mux #(.DATA_W(DATA_W)) u_mux (
        .cfg           (cfg_eff),
        .slot          (st_q.slot),
        .cur_left      (in_left),
        .cur_right     (in_right),
        .cur_cs_left   (in_cs_left),
        .cur_cs_right  (in_cs_right),
        .held_right    (st_q.hold_right),
        .held_cs_left  (st_q.hold_cs_left),
        .held_cs_right (st_q.hold_cs_right),
        .out_data      (mux_data),
        .out_cs        (mux_cs)
    );

    aes_sfm_out_stage #(.DATA_W(DATA_W)) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_data   (mux_data),
        .load_slot_b (st_q.slot == SLOT_B),
        .load_cs     (mux_cs),
        .sf_ready    (sf_ready),
        .can_load    (can_load),
        .sf_valid    (sf_valid),
        .sf_data     (sf_data),
        .sf_slot_b   (sf_slot_b),
        .sf_cs       (sf_cs)
    );

    // checker state: slot of the last delivered subframe, B before the first
    logic last_b_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_b_q <= 1'b1;
        end else if (sf_valid && sf_ready) begin
            last_b_q <= sf_slot_b;
        end
    end

    // R7 (and R1: first delivery is slot A)
    slot_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && sf_ready) |-> (sf_slot_b != last_b_q));

    // R10
    stereo_b_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && st_q.slot == SLOT_B) |-> st_q.cfg.mono);

    // R8
    cfg_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot == SLOT_B) |=> $stable(st_q.cfg));

endmodule

// File: tb/aes_tx_subframe_mapper_bench.sv
module aes_tx_subframe_mapper_bench;

    localparam int DW = 24;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mono = 1'b0, cfg_sel_right = 1'b0, cfg_cs_shared = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DW-1:0] in_left = '0, in_right = '0;
    logic in_cs_left = 1'b0, in_cs_right = 1'b0;
    logic sf_valid;
    logic sf_ready = 1'b0;
    logic [DW-1:0] sf_data;
    logic sf_slot_b;
    logic sf_cs;

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_tx_subframe_mapper #(.DATA_W(DW)) u_aes_tx_subframe_mapper (
        .clk(clk), .rst_n(rst_n),
        .cfg_mono(cfg_mono), .cfg_sel_right(cfg_sel_right), .cfg_cs_shared(cfg_cs_shared),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right),
        .in_cs_left(in_cs_left), .in_cs_right(in_cs_right),
        .sf_valid(sf_valid), .sf_ready(sf_ready),
        .sf_data(sf_data), .sf_slot_b(sf_slot_b), .sf_cs(sf_cs)
    );

    int checks = 0;
    int fails  = 0;
    logic [DW+1:0] exp_q[$];
    string         tag_q[$];
    bit            finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [DW+1:0] act, input logic [DW+1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {data, slot_b, cs}
    task automatic expect_sf(input logic [DW-1:0] d, input logic b, input logic c, input string tag);
        exp_q.push_back({d, b, c});
        tag_q.push_back(tag);
    endtask

    task automatic push_in(input logic [DW-1:0] l, input logic [DW-1:0] r, input logic cl, input logic cr);
        @(negedge clk);
        in_left = l; in_right = r; in_cs_left = cl; in_cs_right = cr; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_frame(input bit mono, input bit sel, input bit shr, input bit scramble,
                              input logic [DW-1:0] l0, input logic [DW-1:0] r0, input logic cl0, input logic cr0,
                              input logic [DW-1:0] l1, input logic [DW-1:0] r1, input logic cl1, input logic cr1,
                              input string tag);
        @(negedge clk);
        cfg_mono = mono; cfg_sel_right = sel; cfg_cs_shared = shr;
        if (!mono) begin
            // R2 R5 R6 R10: stereo frame from one sample
            expect_sf(l0, 1'b0, shr ? (sel ? cr0 : cl0) : cl0, tag);
            expect_sf(r0, 1'b1, shr ? (sel ? cr0 : cl0) : cr0, tag);
        end else begin
            // R3 R4 R5 R6: mono frame from two samples
            expect_sf(sel ? r0 : l0, 1'b0, shr ? (sel ? cr0 : cl0) : cl0, tag);
            expect_sf(sel ? r1 : l1, 1'b1, shr ? (sel ? cr1 : cl1) : cr1, tag);
        end
        push_in(l0, r0, cl0, cr0);
        if (scramble) begin
            // R8: flip every control while the frame is still open
            cfg_mono = ~mono; cfg_sel_right = ~sel; cfg_cs_shared = ~shr;
        end
        if (mono) push_in(l1, r1, cl1, cr1);
    endtask

    // framer-side ready pattern, changed just after each rising edge
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        sf_ready = (cyc % 7 != 3) && (cyc % 11 != 5) && !(cyc > 400 && cyc < 412);
    end

    // monitor: compare at the falling edge, when all inputs are settled
    logic          prev_stall = 1'b0;
    logic [DW+1:0] prev_out   = '0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_stall) begin
                check(sf_valid && ({sf_data, sf_slot_b, sf_cs} == prev_out), "R9 stall hold",
                      {sf_data, sf_slot_b, sf_cs}, prev_out);
            end
            if (sf_valid && sf_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected subframe", {sf_data, sf_slot_b, sf_cs}, '0);
                end else begin
                    logic [DW+1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({sf_data, sf_slot_b, sf_cs} == e, t, {sf_data, sf_slot_b, sf_cs}, e);
                end
            end
            prev_stall = sf_valid && !sf_ready;
            prev_out   = {sf_data, sf_slot_b, sf_cs};
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle output during and right after reset
        check(!sf_valid, "R1 reset valid", {25'd0, sf_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sf_valid, "R1 valid after reset", {25'd0, sf_valid}, '0);

        send_frame(0, 0, 0, 0, 24'h111111, 24'h222222, 1, 0, '0, '0, 0, 0, "R1 R2 R5 R7 first stereo");
        send_frame(1, 0, 0, 0, 24'hA00001, 24'hB00001, 1, 0, 24'hA00002, 24'hB00002, 0, 1, "R3 R4 R5 mono left");
        send_frame(1, 1, 0, 0, 24'hA00003, 24'hB00003, 0, 1, 24'hA00004, 24'hB00004, 1, 0, "R3 R4 R5 mono right");
        send_frame(0, 0, 1, 0, 24'h333333, 24'h444444, 1, 0, '0, '0, 0, 0, "R6 stereo shared left");
        send_frame(0, 1, 1, 0, 24'h555555, 24'h666666, 1, 0, '0, '0, 0, 0, "R6 stereo shared right");
        send_frame(1, 1, 1, 0, 24'hC00001, 24'hD00001, 0, 1, 24'hC00002, 24'hD00002, 1, 0, "R6 mono shared right");
        send_frame(1, 0, 1, 0, 24'hC00003, 24'hD00003, 1, 0, 24'hC00004, 24'hD00004, 0, 1, "R6 mono shared left");
        send_frame(0, 0, 0, 1, 24'h777777, 24'h888888, 0, 1, '0, '0, 0, 0, "R8 stereo mid-frame change");
        send_frame(1, 1, 0, 1, 24'hE00001, 24'hF00001, 1, 0, 24'hE00002, 24'hF00002, 0, 1, "R8 mono mid-frame change");
        send_frame(0, 1, 1, 1, 24'h999999, 24'hAAAAAA, 0, 1, '0, '0, 0, 0, "R8 R6 stereo change");

        for (int i = 0; i < 40; i++) begin
            logic [DW-1:0] a, b, c, d;
            a = 24'h100000 + DW'(i * 3);
            b = 24'h200000 + DW'(i * 5);
            c = 24'h300000 + DW'(i * 7);
            d = 24'h400000 + DW'(i * 11);
            send_frame(i[0], i[1], i[2], i[3], a, b, i[1] ^ i[4], i[0], c, d, i[2], i[3] ^ i[0],
                       "R2 R3 R4 R5 R6 R7 R8 R9 R10 mixed");
        end

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(!sf_valid, "R10 no extra subframe", {25'd0, sf_valid}, '0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule